// File: doc/BRIEF.md
# Programmable Data-Enable Regenerator

This block rebuilds the active-video data-enable for a pixel stream. It uses only the pixel clock, the horizontal and vertical sync inputs and a field flag. Any enable that arrives with the stream plays no part in the rebuilt signal. Configuration inputs place a rectangular active window relative to the sync leading edges:

- a pixel delay from the horizontal edge;
- a line delay from the vertical edge;
- a window width in pixels and a height in lines;
- a small interlace offset that lengthens the vertical delay in the second field.

A select input chooses the output enable. It is either the rebuilt window or the incoming enable, passed straight through. Inside the window the block also reports the pixel index within the line and the line index within the window.

Each axis runs one small state machine with four states: IDLE, BLANK, ACTIVE and DONE. IDLE holds from reset until the axis sees its first restart edge. A restart edge moves the axis to BLANK with its counter at zero. BLANK moves to ACTIVE once the counter reaches the delay. ACTIVE moves to DONE once the counter reaches delay plus length. BLANK goes straight to DONE when the length is zero. DONE holds until the next restart edge, which also ends any unfinished window. The horizontal axis restarts on a horizontal edge and counts every clock. The vertical axis restarts on a vertical edge and counts horizontal edges.

Settings are copied into shadow registers at each vertical leading edge, so one frame never mixes two settings. The clock on which the vertical edge is seen already uses the new values.

Top module: `de_regen`

## Requirements
- R1: A sync leading edge is the clock on which the sync input first equals its polarity input (1 = active high, 0 = active low). After that clock the matching counter reads 0, so the edge pixel is horizontal position 0 and the edge line is vertical line 0.
- R2: With generation selected, the enable is high exactly for horizontal positions from the pixel delay up to the pixel delay plus the width, minus one.
- R3: The enable is high only on vertical lines from the effective line delay up to the effective line delay plus the height, minus one. Lines are counted by horizontal leading edges after the vertical edge.
- R4: The field flag is sampled at the vertical edge. When it is 1, the interlace offset is added to the line delay for that frame.
- R5: While the enable is high, `pix_x` equals the position minus the pixel delay and `line_y` equals the line minus the line delay. Both read 0 outside the window.
- R6: A horizontal edge before the end of the line's window ends the enable at once. A vertical edge before the last window line ends the window.
- R7: Changes to delay, size, offset or field made mid-frame take effect only at the next vertical leading edge.
- R8: When the force input is 0, `de_out` follows `de_in` combinationally. When it is 1, `de_in` has no effect on `de_out`.
- R9: A width or height of zero gives no enable in that frame.
- R10: After reset the outputs are 0, and no enable appears before the first vertical leading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| field_id | input | 1 | Field flag, 1 = second field |
| de_in | input | 1 | Enable received with the stream |
| cfg_hs_pol | input | 1 | Horizontal sync active level |
| cfg_vs_pol | input | 1 | Vertical sync active level |
| cfg_force_gen | input | 1 | 1 = rebuilt enable, 0 = pass-through |
| cfg_h_delay | input | HDLY_W | Pixels from horizontal edge to first active pixel |
| cfg_v_delay | input | VDLY_W | Lines from vertical edge to first active line |
| cfg_il_offset | input | ILO_W | Extra lines of delay in the second field |
| cfg_width | input | SIZE_W | Active pixels per line |
| cfg_height | input | SIZE_W | Active lines per frame |
| de_out | output | 1 | Selected data-enable |
| pix_x | output | SIZE_W | Pixel index inside the window |
| line_y | output | SIZE_W | Line index inside the window |

## Verification
The bench builds the block with its default widths: 12-bit sizes, a 10-bit pixel delay, a 6-bit line delay and a 3-bit offset. It drives the configuration inputs with small values, such as a 3-pixel delay, a 5-pixel width, 12-clock lines and 8-line frames. Every state transition therefore comes up within a few hundred clocks. These values bring into reach lines shorter than the window and frames shorter than the window. They also cover a second-field offset large enough to push the window past the next frame edge, mid-frame changes to the width, and both sync polarities.

// File: rtl/de_regen_pkg.sv
package de_regen_pkg;
    // Per-axis window phase
    typedef enum logic [1:0] {
        AX_IDLE,
        AX_BLANK,
        AX_ACTIVE,
        AX_DONE
    } axis_state_t;
endpackage

// File: rtl/de_regen_edge.sv
module de_regen_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic pol,
    output logic lead
);
    logic act;
    logic act_q;

    assign act = (sync_in == pol);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b1;
        else        act_q <= act;
    end

    assign lead = act & ~act_q;
endmodule

// File: rtl/de_regen_axis.sv
module de_regen_axis
    import de_regen_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [CNT_W-1:0] offs,
    input  logic [CNT_W-1:0] len,
    output logic             active,
    output logic [POS_W-1:0] pos
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    axis_state_t     state_q, state_n, base;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [POS_W-1:0] pos_q, pos_n;
    logic [CNT_W:0]   stop;

    assign stop = {1'b0, offs} + {1'b0, len};
    assign base = restart ? AX_BLANK : state_q;

    always_comb begin
        if (restart)
            cnt_n = '0;
        else if (step && state_q != AX_IDLE && cnt_q != CNT_MAX)
            cnt_n = cnt_q + 1'b1;
        else
            cnt_n = cnt_q;
    end

    // next-state process
    always_comb begin
        state_n = base;
        unique case (base)
            AX_IDLE:   state_n = AX_IDLE;
            AX_BLANK: begin
                if ({1'b0, cnt_n} >= stop)  state_n = AX_DONE;
                else if (cnt_n >= offs)     state_n = AX_ACTIVE;
                else                        state_n = AX_BLANK;
            end
            AX_ACTIVE: begin
                if ({1'b0, cnt_n} >= stop)  state_n = AX_DONE;
                else                        state_n = AX_ACTIVE;
            end
            AX_DONE:   state_n = AX_DONE;
        endcase
    end

    // output (position) process
    always_comb begin
        pos_n = '0;
        if (state_n == AX_ACTIVE && base == AX_ACTIVE)
            pos_n = step ? pos_q + 1'b1 : pos_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AX_IDLE;
            cnt_q   <= '0;
            pos_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            pos_q   <= pos_n;
        end
    end

    assign active = (state_q == AX_ACTIVE);
    assign pos    = pos_q;
endmodule

// File: rtl/de_regen.sv
module de_regen
    import de_regen_pkg::*;
#(
    parameter int SIZE_W   = 12,
    parameter int HDLY_W   = 10,
    parameter int VDLY_W   = 6,
    parameter int ILO_W    = 3,
    parameter int DEF_HDLY = 260,
    parameter int DEF_VDLY = 24,
    parameter int DEF_WID  = 1280,
    parameter int DEF_HGT  = 720
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              field_id,
    input  logic              de_in,
    input  logic              cfg_hs_pol,
    input  logic              cfg_vs_pol,
    input  logic              cfg_force_gen,
    input  logic [HDLY_W-1:0] cfg_h_delay,
    input  logic [VDLY_W-1:0] cfg_v_delay,
    input  logic [ILO_W-1:0]  cfg_il_offset,
    input  logic [SIZE_W-1:0] cfg_width,
    input  logic [SIZE_W-1:0] cfg_height,
    output logic              de_out,
    output logic [SIZE_W-1:0] pix_x,
    output logic [SIZE_W-1:0] line_y
);
    localparam int CNT_W = SIZE_W + 1;

    logic hs_edge, vs_edge;

    de_regen_edge u_hs_edge (
        .clk(clk), .rst_n(rst_n), .sync_in(hsync), .pol(cfg_hs_pol), .lead(hs_edge)
    );
    de_regen_edge u_vs_edge (
        .clk(clk), .rst_n(rst_n), .sync_in(vsync), .pol(cfg_vs_pol), .lead(vs_edge)
    );

    // Shadow settings, captured at each vertical leading edge
    logic [HDLY_W-1:0] sh_hdly;
    logic [VDLY_W-1:0] sh_vdly;
    logic [ILO_W-1:0]  sh_ilo;
    logic [SIZE_W-1:0] sh_width, sh_height;
    logic              sh_field;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_hdly   <= HDLY_W'(DEF_HDLY);
            sh_vdly   <= VDLY_W'(DEF_VDLY);
            sh_ilo    <= '0;
            sh_width  <= SIZE_W'(DEF_WID);
            sh_height <= SIZE_W'(DEF_HGT);
            sh_field  <= 1'b0;
        end else if (vs_edge) begin
            sh_hdly   <= cfg_h_delay;
            sh_vdly   <= cfg_v_delay;
            sh_ilo    <= cfg_il_offset;
            sh_width  <= cfg_width;
            sh_height <= cfg_height;
            sh_field  <= field_id;
        end
    end

    // Settings seen this clock: the incoming ones on the capture clock
    logic [HDLY_W-1:0] eff_hdly;
    logic [VDLY_W-1:0] eff_vdly;
    logic [ILO_W-1:0]  eff_ilo;
    logic [SIZE_W-1:0] eff_width, eff_height;
    logic              eff_field;
    logic [CNT_W-1:0]  eff_voffs;

    assign eff_hdly   = vs_edge ? cfg_h_delay   : sh_hdly;
    assign eff_vdly   = vs_edge ? cfg_v_delay   : sh_vdly;
    assign eff_ilo    = vs_edge ? cfg_il_offset : sh_ilo;
    assign eff_width  = vs_edge ? cfg_width     : sh_width;
    assign eff_height = vs_edge ? cfg_height    : sh_height;
    assign eff_field  = vs_edge ? field_id      : sh_field;
    assign eff_voffs  = CNT_W'(eff_vdly) + (eff_field ? CNT_W'(eff_ilo) : '0);

    logic              h_act, v_act, de_gen;
    logic [SIZE_W-1:0] h_pos, v_pos;

    de_regen_axis #(.CNT_W(CNT_W), .POS_W(SIZE_W)) u_h_axis (
        .clk(clk), .rst_n(rst_n),
        .restart(hs_edge), .step(1'b1),
        .offs(CNT_W'(eff_hdly)), .len(CNT_W'(eff_width)),
        .active(h_act), .pos(h_pos)
    );

    de_regen_axis #(.CNT_W(CNT_W), .POS_W(SIZE_W)) u_v_axis (
        .clk(clk), .rst_n(rst_n),
        .restart(vs_edge), .step(hs_edge),
        .offs(eff_voffs), .len(CNT_W'(eff_height)),
        .active(v_act), .pos(v_pos)
    );

    assign de_gen = h_act & v_act;
    assign de_out = cfg_force_gen ? de_gen : de_in;
    assign pix_x  = de_gen ? h_pos : '0;
    assign line_y = de_gen ? v_pos : '0;
endmodule

// File: rtl/de_regen_chk.sv
module de_regen_chk #(
    parameter int SIZE_W = 12,
    parameter int HDLY_W = 10,
    parameter int VDLY_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hs_edge,
    input logic              vs_edge,
    input logic              de_gen,
    input logic [HDLY_W-1:0] eff_hdly,
    input logic [SIZE_W-1:0] pix_x,
    input logic [SIZE_W-1:0] line_y,
    input logic [HDLY_W-1:0] sh_hdly,
    input logic [VDLY_W-1:0] sh_vdly,
    input logic [SIZE_W-1:0] sh_width,
    input logic [SIZE_W-1:0] sh_height
);
    // R1 / R6: a horizontal edge with nonzero delay closes the window next clock
    a_r6_hedge_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_edge && eff_hdly != '0) |=> !de_gen);

    // R5: pixel index advances by one across consecutive enabled clocks of a line
    a_r5_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
        (de_gen && $past(de_gen) && !$past(hs_edge)) |-> (pix_x == $past(pix_x) + 1'b1));

    // R5: line index starts from zero after a vertical edge
    a_r5_line_zero: assert property (@(posedge clk) disable iff (!rst_n)
        vs_edge |=> (line_y == '0));

    // R7: shadow settings only move on a vertical edge
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_edge |=> $stable({sh_hdly, sh_vdly, sh_width, sh_height}));

    // R9: zero width yields no enable
    a_r9_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_width == '0 && !vs_edge) |=> !de_gen);
endmodule

bind de_regen de_regen_chk #(.SIZE_W(SIZE_W), .HDLY_W(HDLY_W), .VDLY_W(VDLY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hs_edge(hs_edge), .vs_edge(vs_edge),
    .de_gen(de_gen), .eff_hdly(eff_hdly), .pix_x(pix_x), .line_y(line_y),
    .sh_hdly(sh_hdly), .sh_vdly(sh_vdly), .sh_width(sh_width), .sh_height(sh_height)
);

// File: tb/de_regen_bench.sv
module de_regen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0, vsync = 1'b0, field_id = 1'b0, de_in = 1'b0;
    logic        cfg_hs_pol = 1'b1, cfg_vs_pol = 1'b1, cfg_force_gen = 1'b1;
    logic [9:0]  cfg_h_delay = 10'd3;
    logic [5:0]  cfg_v_delay = 6'd2;
    logic [2:0]  cfg_il_offset = 3'd0;
    logic [11:0] cfg_width = 12'd5, cfg_height = 12'd3;
    logic        de_out;
    logic [11:0] pix_x, line_y;

    always #4 clk = ~clk;

    de_regen u_de_regen (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .field_id(field_id),
        .de_in(de_in), .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
        .cfg_force_gen(cfg_force_gen), .cfg_h_delay(cfg_h_delay), .cfg_v_delay(cfg_v_delay),
        .cfg_il_offset(cfg_il_offset), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .de_out(de_out), .pix_x(pix_x), .line_y(line_y)
    );

    int    n_run = 0, n_fail = 0, de_cnt = 0;
    bit    cmp_en = 1'b0;
    string cur_req = "R10";

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_hd, m_vd, m_ilo, m_w, m_h, m_fld;
    int hpos, vline;
    bit hvalid, vvalid, hs_prev, vs_prev, m_gen;

    always @(posedge clk) begin
        if (!rst_n) begin
            hs_prev = 1; vs_prev = 1; hvalid = 0; vvalid = 0;
            m_hd = 260; m_vd = 24; m_ilo = 0; m_w = 1280; m_h = 720; m_fld = 0;
            hpos = 0; vline = 0;
        end else begin
            bit ha, va, he, ve;
            ha = (hsync == cfg_hs_pol); va = (vsync == cfg_vs_pol);
            he = ha && !hs_prev;        ve = va && !vs_prev;
            hs_prev = ha;               vs_prev = va;
            if (ve) begin
                m_hd = cfg_h_delay; m_vd = cfg_v_delay; m_ilo = cfg_il_offset;
                m_w = cfg_width; m_h = cfg_height; m_fld = field_id;
                vline = 0; vvalid = 1;
            end else if (he && vvalid) vline++;
            if (he) begin hpos = 0; hvalid = 1; end
            else if (hvalid) hpos++;
        end
        begin
            int vd;
            vd = m_vd + (m_fld ? m_ilo : 0);
            m_gen = hvalid && vvalid && hpos >= m_hd && hpos < m_hd + m_w
                    && vline >= vd && vline < vd + m_h;
            #2;
            if (cmp_en) begin
                int exp_de;
                exp_de = cfg_force_gen ? int'(m_gen) : int'(de_in);
                check(de_out === exp_de[0], cur_req, int'(de_out), exp_de);
                check(pix_x == (m_gen ? 12'(hpos - m_hd) : 12'd0), "R5", int'(pix_x),
                      m_gen ? hpos - m_hd : 0);
                check(line_y == (m_gen ? 12'(vline - vd) : 12'd0), "R5", int'(line_y),
                      m_gen ? vline - vd : 0);
            end
            if (de_out === 1'b1) de_cnt++;
        end
    end

    task automatic run_frame(input int nlines, input int htotal, input int fld,
                             input bit with_vs, input int chg_line, input int chg_w,
                             output int cnt);
        @(posedge clk); #3; de_cnt = 0;
        for (int l = 0; l < nlines; l++) begin
            for (int p = 0; p < htotal; p++) begin
                @(negedge clk);
                hsync    = (p < 2) ? cfg_hs_pol : ~cfg_hs_pol;
                vsync    = (with_vs && l == 0) ? cfg_vs_pol : ~cfg_vs_pol;
                field_id = fld[0];
                de_in    = ((p + l) % 3 == 0);
                if (l == chg_line && p == 0) cfg_width = 12'(chg_w);
            end
        end
        @(posedge clk); #3;
        cnt = de_cnt;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int c, exp_pt;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(de_out == 1'b0, "R10", int'(de_out), 0);
        check(pix_x == 12'd0 && line_y == 12'd0, "R10", int'(pix_x) + int'(line_y), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R10: horizontal edges alone give no enable
        run_frame(4, 12, 0, 1'b0, -1, 0, c);
        check(c == 0, "R10", c, 0);

        // R2/R3: basic window, two frames
        cur_req = "R2";
        run_frame(8, 12, 0, 1'b1, -1, 0, c);
        check(c == 15, "R2", c, 15);
        cur_req = "R3";
        run_frame(8, 12, 0, 1'b1, -1, 0, c);
        check(c == 15, "R3", c, 15);

        // R4: second field with offset
        cur_req = "R4";
        cfg_il_offset = 3'd2;
        run_frame(8, 12, 1, 1'b1, -1, 0, c);
        check(c == 15, "R4", c, 15);
        cfg_il_offset = 3'd5;
        run_frame(8, 12, 1, 1'b1, -1, 0, c);
        check(c == 5, "R4", c, 5);
        run_frame(8, 12, 0, 1'b1, -1, 0, c);
        check(c == 15, "R4", c, 15);
        cfg_il_offset = 3'd0;

        // R1: active-low syncs
        cur_req = "R1";
        @(negedge clk);
        cfg_hs_pol = 1'b0; cfg_vs_pol = 1'b0; hsync = 1'b1; vsync = 1'b1;
        run_frame(8, 12, 0, 1'b1, -1, 0, c);
        check(c == 15, "R1", c, 15);

        // R7: mid-frame width change deferred
        cur_req = "R7";
        run_frame(8, 12, 0, 1'b1, 3, 7, c);
        check(c == 15, "R7", c, 15);
        run_frame(8, 12, 0, 1'b1, -1, 0, c);
        check(c == 21, "R7", c, 21);
        cfg_width = 12'd5;

        // R6: short lines and a short frame
        cur_req = "R6";
        run_frame(8, 6, 0, 1'b1, -1, 0, c);
        check(c == 9, "R6", c, 9);
        run_frame(3, 12, 0, 1'b1, -1, 0, c);
        check(c == 5, "R6", c, 5);
        run_frame(8, 12, 0, 1'b1, -1, 0, c);
        check(c == 15, "R6", c, 15);

        // R9: zero width, zero height
        cur_req = "R9";
        cfg_width = 12'd0;
        run_frame(8, 12, 0, 1'b1, -1, 0, c);
        check(c == 0, "R9", c, 0);
        cfg_width = 12'd5; cfg_height = 12'd0;
        run_frame(8, 12, 0, 1'b1, -1, 0, c);
        check(c == 0, "R9", c, 0);
        cfg_height = 12'd3;

        // R8: pass-through, then generation ignoring de_in
        cur_req = "R8";
        cfg_force_gen = 1'b0;
        exp_pt = 0;
        for (int l = 0; l < 8; l++)
            for (int p = 0; p < 12; p++)
                if ((p + l) % 3 == 0) exp_pt++;
        run_frame(8, 12, 0, 1'b1, -1, 0, c);
        check(c == exp_pt, "R8", c, exp_pt);
        cfg_force_gen = 1'b1;
        run_frame(8, 12, 0, 1'b1, -1, 0, c);
        check(c == 15, "R8", c, 15);

        cmp_en = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule